// File: doc/BRIEF.md
# Static memory bus timing controller

This block lets an on-chip master reach asynchronous static memories (SRAM, NOR-style parts, pseudo-static RAM) through a plain 32-bit request port. Every request is latched when the block is idle. It is then played out on an external 8-bit or 16-bit data bus as a short run of narrow accesses, each with its own address, chip select, output enable, write enable and byte lane selects. When the last narrow access has finished, the block pulses a ready strobe and returns the assembled read word.

Each bank has its own chip select, bus width bit and two 12-bit timing words, one for reads and one for writes. These are held on static configuration inputs. A timing word gives three things: how long the strobe waits after the chip select falls, how many extra cycles the strobe stays asserted, and how many idle cycles separate one narrow access from the next. A wait input from the device, brought in through a synchronizer, can hold the strobe phase open for as long as the device needs.

Top module: `smem_ctrl`

## Requirements
- R1: While `rstN` is low and after its release, every chip select, `memOeN` and `memWeN` is high, `memDataOe` is low and `reqReady` is low until a request is taken.
- R2: A request to a bank whose `cfgBusWide` bit is 1 runs two 16-bit accesses at byte addresses base and base+2. A bank whose bit is 0 gets four 8-bit accesses at base..base+3. Here base is `reqAddr` with its two low bits cleared, and the lowest byte lane goes first (little-endian). On an 8-bit bank, data uses `memDataIn[7:0]` / `memDataOut[7:0]`.
- R3: Bank b uses the slice `[12*b+11:12*b]` of `cfgRdTiming` for reads and of `cfgWrTiming` for writes. Within a slice, bits [3:0] are the enable delay, [7:4] the wait states and [11:8] the turnaround count, each 0..15.
- R4: Each narrow access holds its bank's chip select low with both strobes high for enable-delay cycles. It then asserts its strobe for 1 + wait-state cycles, provided `memWait` stays low.
- R5: Between two narrow accesses of one request, all chip selects and strobes are high for exactly turnaround cycles.
- R6: `reqReady` is a one-cycle pulse in the cycle after the last strobe phase ends. With `memWait` low, it comes enable-delay·n + (1+wait)·n + turnaround·(n−1) + 1 cycles after the accepting edge, where n is the number of narrow accesses. `rspRdata` holds the assembled read word while `reqReady` is high.
- R7: On writes, `memBeN` (active low) enables only the bytes set in `reqByteEn`. On a 16-bit bank, bit 0 is the low byte. Reads drive `memBeN` = 00 on 16-bit banks and 10 on 8-bit banks. A write access whose enabled lane set is empty keeps `memWeN` high for its whole strobe phase, so memory is left untouched.
- R8: `memWait` passes through two flops. While the synchronized level is high and the wait-state count has run out, the strobe phase is held.
- R9: At most one chip select is low at a time, and it is the one for the requested bank.
- R10: `memOeN` and `memWeN` are never low together. `memDataOe` is high only during write accesses.
- R11: Request fields are captured on acceptance. Changes to them before `reqReady` have no effect, and the requester drops `reqValid` in the cycle `reqReady` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgBusWide | input | NUM_BANKS | Per bank: 1 = 16-bit bus, 0 = 8-bit bus |
| cfgRdTiming | input | NUM_BANKS*12 | Per-bank read timing words |
| cfgWrTiming | input | NUM_BANKS*12 | Per-bank write timing words |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqBank | input | BANK_W | Target bank |
| reqAddr | input | ADDR_W | Byte address |
| reqWdata | input | 32 | Write word |
| reqByteEn | input | 4 | Write byte enables |
| reqReady | output | 1 | Request completed (one cycle) |
| rspRdata | output | 32 | Assembled read word |
| memCsN | output | NUM_BANKS | Active-low chip selects |
| memAddr | output | ADDR_W | Byte address of the current narrow access |
| memOeN | output | 1 | Active-low output enable |
| memWeN | output | 1 | Active-low write enable |
| memBeN | output | 2 | Active-low byte lane selects |
| memDataOut | output | 16 | Write data to the bus |
| memDataOe | output | 1 | Bus driver enable |
| memDataIn | input | 16 | Read data from the bus |
| memWait | input | 1 | Device wait request, asynchronous, active high |

## Verification
The bench builds the block with two banks and a 12-bit address. Bank 0 is strapped to a 16-bit bus and bank 1 to an 8-bit bus, so both split factors and both lane-select schemes occur in the same run. The narrow address keeps the device model small while random low address bits still test base alignment. Timing words range from all zeros to all fifteens, with read and write words chosen differently, so a swapped set or slice shows up in the measured phase lengths.

// File: rtl/smem_ctrl_pkg.sv
package smem_ctrl_pkg;

  localparam int TIMING_W = 12;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_DATA,
    ST_TURN,
    ST_FIN
  } ctrlState_e;

  // bit order of the timing word is part of the configuration contract
  typedef struct packed {
    logic [3:0] turn;
    logic [3:0] waitStates;
    logic [3:0] enDly;
  } timing_t;

  typedef struct packed {
    logic selectIncoming;
    logic latchReq;
    logic captureBeat;
    logic advanceBeat;
    logic csActive;
    logic oeActive;
    logic weActive;
    logic driveData;
  } ctrlStrobe_t;

endpackage

// File: rtl/smem_ctrl_fsm.sv
module smem_ctrl_fsm
  import smem_ctrl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  timing_t     timing,
  input  logic        isWrite,
  input  logic        lastBeat,
  input  logic        laneAny,
  input  logic        memWait,
  output ctrlStrobe_t strobe,
  output logic        reqReady
);

  ctrlState_e state, stateNext;
  logic [3:0] cnt, cntNext;
  logic       finishing;
  logic       waitS1, waitS2;
  logic       dataEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitS1 <= 1'b0;
      waitS2 <= 1'b0;
    end else begin
      waitS1 <= memWait;
      waitS2 <= waitS1;
    end
  end

  assign dataEnd = (state == ST_DATA) && (cnt == 4'd0) && !waitS2;

  always_comb begin
    strobe = '0;
    strobe.selectIncoming = (state == ST_IDLE);
    strobe.latchReq       = (state == ST_IDLE) && reqValid;
    strobe.csActive       = (state == ST_SETUP) || (state == ST_DATA);
    strobe.oeActive       = (state == ST_DATA) && !isWrite;
    strobe.weActive       = (state == ST_DATA) && isWrite && laneAny;
    strobe.driveData      = strobe.csActive && isWrite;
    strobe.captureBeat    = dataEnd && !isWrite;
    strobe.advanceBeat    = dataEnd && !lastBeat;
  end

  assign reqReady = (state == ST_FIN);

  always_comb begin
    stateNext = state;
    cntNext   = cnt;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          if (timing.enDly != 4'd0) begin
            stateNext = ST_SETUP;
            cntNext   = timing.enDly - 4'd1;
          end else begin
            stateNext = ST_DATA;
            cntNext   = timing.waitStates;
          end
        end
      end
      ST_SETUP: begin
        if (cnt == 4'd0) begin
          stateNext = ST_DATA;
          cntNext   = timing.waitStates;
        end else begin
          cntNext = cnt - 4'd1;
        end
      end
      ST_DATA: begin
        if (cnt != 4'd0) begin
          cntNext = cnt - 4'd1;
        end else if (!waitS2) begin
          if (lastBeat) begin
            stateNext = ST_FIN;
          end else if (timing.turn != 4'd0) begin
            stateNext = ST_TURN;
            cntNext   = timing.turn - 4'd1;
          end else if (timing.enDly != 4'd0) begin
            stateNext = ST_SETUP;
            cntNext   = timing.enDly - 4'd1;
          end else begin
            stateNext = ST_DATA;
            cntNext   = timing.waitStates;
          end
        end
      end
      ST_TURN: begin
        if (cnt != 4'd0) begin
          cntNext = cnt - 4'd1;
        end else if (finishing) begin
          stateNext = ST_IDLE;
        end else if (timing.enDly != 4'd0) begin
          stateNext = ST_SETUP;
          cntNext   = timing.enDly - 4'd1;
        end else begin
          stateNext = ST_DATA;
          cntNext   = timing.waitStates;
        end
      end
      ST_FIN: begin
        if (timing.turn != 4'd0) begin
          stateNext = ST_TURN;
          cntNext   = timing.turn - 4'd1;
        end else begin
          stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= 4'd0;
      finishing <= 1'b0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
      if (state == ST_FIN)
        finishing <= 1'b1;
      else if (strobe.latchReq)
        finishing <= 1'b0;
    end
  end

endmodule

// File: rtl/smem_ctrl_dp.sv
module smem_ctrl_dp
  import smem_ctrl_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 24,
  parameter int BANK_W    = 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctrlStrobe_t                   strobe,
  input  logic [NUM_BANKS-1:0]          cfgBusWide,
  input  logic [NUM_BANKS*TIMING_W-1:0] cfgRdTiming,
  input  logic [NUM_BANKS*TIMING_W-1:0] cfgWrTiming,
  input  logic                          reqWrite,
  input  logic [BANK_W-1:0]             reqBank,
  input  logic [ADDR_W-1:0]             reqAddr,
  input  logic [31:0]                   reqWdata,
  input  logic [3:0]                    reqByteEn,
  input  logic [15:0]                   memDataIn,
  output timing_t                       timing,
  output logic                          isWrite,
  output logic                          lastBeat,
  output logic                          laneAny,
  output logic [31:0]                   rspRdata,
  output logic [NUM_BANKS-1:0]          memCsN,
  output logic [ADDR_W-1:0]             memAddr,
  output logic                          memOeN,
  output logic                          memWeN,
  output logic [1:0]                    memBeN,
  output logic [15:0]                   memDataOut,
  output logic                          memDataOe
);

  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(3);

  timing_t rdTm [NUM_BANKS];
  timing_t wrTm [NUM_BANKS];

  logic              lWrite, lWide;
  logic [BANK_W-1:0] lBank;
  logic [ADDR_W-1:0] lAddr;
  logic [31:0]       lWdata;
  logic [3:0]        lBe;
  logic [1:0]        beat;
  logic [31:0]       rdAsm;
  logic [BANK_W-1:0] selBank;
  logic              selWrite;
  logic [1:0]        wrLanes;
  logic [1:0]        beatOffset;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    assign rdTm[g]   = timing_t'(cfgRdTiming[g*TIMING_W +: TIMING_W]);
    assign wrTm[g]   = timing_t'(cfgWrTiming[g*TIMING_W +: TIMING_W]);
    assign memCsN[g] = !(strobe.csActive && (lBank == BANK_W'(g)));
  end

  assign selBank  = strobe.selectIncoming ? reqBank  : lBank;
  assign selWrite = strobe.selectIncoming ? reqWrite : lWrite;
  assign timing   = selWrite ? wrTm[selBank] : rdTm[selBank];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lWrite <= 1'b0;
      lWide  <= 1'b0;
      lBank  <= '0;
      lAddr  <= '0;
      lWdata <= '0;
      lBe    <= '0;
      beat   <= '0;
      rdAsm  <= '0;
    end else if (strobe.latchReq) begin
      lWrite <= reqWrite;
      lWide  <= cfgBusWide[reqBank];
      lBank  <= reqBank;
      lAddr  <= reqAddr;
      lWdata <= reqWdata;
      lBe    <= reqByteEn;
      beat   <= '0;
      rdAsm  <= '0;
    end else begin
      if (strobe.captureBeat) begin
        if (lWide)
          rdAsm[{beat[0], 4'b0000} +: 16] <= memDataIn;
        else
          rdAsm[{beat, 3'b000} +: 8] <= memDataIn[7:0];
      end
      if (strobe.advanceBeat)
        beat <= beat + 2'd1;
    end
  end

  assign isWrite    = lWrite;
  assign lastBeat   = lWide ? (beat == 2'd1) : (beat == 2'd3);
  assign wrLanes    = lWide ? lBe[{beat[0], 1'b0} +: 2] : {1'b0, lBe[beat]};
  assign laneAny    = !lWrite || (wrLanes != 2'b00);
  assign beatOffset = lWide ? {beat[0], 1'b0} : beat;
  assign memAddr    = (lAddr & ALIGN_MASK) + ADDR_W'(beatOffset);

  always_comb begin
    if (!strobe.csActive)
      memBeN = 2'b11;
    else if (lWrite)
      memBeN = ~wrLanes;
    else
      memBeN = lWide ? 2'b00 : 2'b10;
  end

  assign memDataOut = lWide ? lWdata[{beat[0], 4'b0000} +: 16]
                            : {8'h00, lWdata[{beat, 3'b000} +: 8]};
  assign memDataOe  = strobe.driveData;
  assign memOeN     = !strobe.oeActive;
  assign memWeN     = !strobe.weActive;
  assign rspRdata   = rdAsm;

endmodule

// File: rtl/smem_ctrl.sv
module smem_ctrl
  import smem_ctrl_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 24,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_BANKS-1:0]          cfgBusWide,
  input  logic [NUM_BANKS*TIMING_W-1:0] cfgRdTiming,
  input  logic [NUM_BANKS*TIMING_W-1:0] cfgWrTiming,
  input  logic                          reqValid,
  input  logic                          reqWrite,
  input  logic [BANK_W-1:0]             reqBank,
  input  logic [ADDR_W-1:0]             reqAddr,
  input  logic [31:0]                   reqWdata,
  input  logic [3:0]                    reqByteEn,
  output logic                          reqReady,
  output logic [31:0]                   rspRdata,
  output logic [NUM_BANKS-1:0]          memCsN,
  output logic [ADDR_W-1:0]             memAddr,
  output logic                          memOeN,
  output logic                          memWeN,
  output logic [1:0]                    memBeN,
  output logic [15:0]                   memDataOut,
  output logic                          memDataOe,
  input  logic [15:0]                   memDataIn,
  input  logic                          memWait
);

  ctrlStrobe_t strobe;
  timing_t     timing;
  logic        isWrite, lastBeat, laneAny;

  smem_ctrl_fsm u_fsm (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .timing   (timing),
    .isWrite  (isWrite),
    .lastBeat (lastBeat),
    .laneAny  (laneAny),
    .memWait  (memWait),
    .strobe   (strobe),
    .reqReady (reqReady)
  );

  smem_ctrl_dp #(
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W),
    .BANK_W    (BANK_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .cfgBusWide  (cfgBusWide),
    .cfgRdTiming (cfgRdTiming),
    .cfgWrTiming (cfgWrTiming),
    .reqWrite    (reqWrite),
    .reqBank     (reqBank),
    .reqAddr     (reqAddr),
    .reqWdata    (reqWdata),
    .reqByteEn   (reqByteEn),
    .memDataIn   (memDataIn),
    .timing      (timing),
    .isWrite     (isWrite),
    .lastBeat    (lastBeat),
    .laneAny     (laneAny),
    .rspRdata    (rspRdata),
    .memCsN      (memCsN),
    .memAddr     (memAddr),
    .memOeN      (memOeN),
    .memWeN      (memWeN),
    .memBeN      (memBeN),
    .memDataOut  (memDataOut),
    .memDataOe   (memDataOe)
  );

endmodule

// File: rtl/smem_ctrl_chk.sv
module smem_ctrl_chk #(
  parameter int NUM_BANKS = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_BANKS-1:0] memCsN,
  input logic                 memOeN,
  input logic                 memWeN,
  input logic                 memDataOe,
  input logic                 reqReady,
  input logic                 memWait
);

  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(!memOeN && !memWeN));

  assert_no_contention_R10: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> !memDataOe);

  assert_single_cs_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~memCsN));

  assert_strobe_in_cs_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!memOeN || !memWeN) |-> ($countones(~memCsN) == 1));

  assert_ready_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |=> !reqReady);

  assert_wait_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!memOeN && $past(memWait, 2) && $past(rstN, 2)) |=> !memOeN);

endmodule

bind smem_ctrl smem_ctrl_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .memCsN    (memCsN),
  .memOeN    (memOeN),
  .memWeN    (memWeN),
  .memDataOe (memDataOe),
  .reqReady  (reqReady),
  .memWait   (memWait)
);

// File: tb/smem_ctrl_bench.sv
module smem_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NB = 2;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [1:0]    cfgBusWide = 2'b01;
  logic [23:0]   cfgRdTiming = '0;
  logic [23:0]   cfgWrTiming = '0;
  logic          reqValid = 1'b0;
  logic          reqWrite = 1'b0;
  logic [0:0]    reqBank = '0;
  logic [AW-1:0] reqAddr = '0;
  logic [31:0]   reqWdata = '0;
  logic [3:0]    reqByteEn = '0;
  logic          reqReady;
  logic [31:0]   rspRdata;
  logic [1:0]    memCsN;
  logic [AW-1:0] memAddr;
  logic          memOeN, memWeN, memDataOe;
  logic [1:0]    memBeN;
  logic [15:0]   memDataOut;
  logic [15:0]   memDataIn;
  logic          memWait = 1'b0;

  int checks = 0;
  int errors = 0;

  logic [7:0] devMem [NB][256];
  logic [7:0] refMem [NB][256];
  logic [7:0] devAddr;

  always #(CLK_PERIOD/2) clk = ~clk;

  smem_ctrl #(.NUM_BANKS(NB), .ADDR_W(AW)) u_smem_ctrl (
    .clk(clk), .rstN(rstN), .cfgBusWide(cfgBusWide),
    .cfgRdTiming(cfgRdTiming), .cfgWrTiming(cfgWrTiming),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqBank(reqBank),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqByteEn(reqByteEn),
    .reqReady(reqReady), .rspRdata(rspRdata), .memCsN(memCsN),
    .memAddr(memAddr), .memOeN(memOeN), .memWeN(memWeN), .memBeN(memBeN),
    .memDataOut(memDataOut), .memDataOe(memDataOe), .memDataIn(memDataIn),
    .memWait(memWait)
  );

  function automatic logic [7:0] pat(int b, int i);
    return 8'(b * 91 + i * 13 + 7);
  endfunction

  // device model: bank 0 is 16 bits wide, bank 1 is 8 bits wide
  assign devAddr = memAddr[7:0];

  always @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < NB; b++)
        for (int i = 0; i < 256; i++) devMem[b][i] <= pat(b, i);
    end else begin
      if (!memCsN[0] && !memWeN) begin
        if (!memBeN[0]) devMem[0][devAddr & 8'hFE] <= memDataOut[7:0];
        if (!memBeN[1]) devMem[0][devAddr | 8'h01] <= memDataOut[15:8];
      end
      if (!memCsN[1] && !memWeN && !memBeN[0])
        devMem[1][devAddr] <= memDataOut[7:0];
    end
  end

  always_comb begin
    memDataIn = 16'h0000;
    if (!memCsN[0] && !memOeN)
      memDataIn = {devMem[0][devAddr | 8'h01], devMem[0][devAddr & 8'hFE]};
    else if (!memCsN[1] && !memOeN)
      memDataIn = {8'h00, devMem[1][devAddr]};
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] refWord(int b, logic [7:0] base);
    return {refMem[b][base + 8'd3], refMem[b][base + 8'd2],
            refMem[b][base + 8'd1], refMem[b][base]};
  endfunction

  function automatic logic [31:0] devWord(int b, logic [7:0] base);
    return {devMem[b][base + 8'd3], devMem[b][base + 8'd2],
            devMem[b][base + 8'd1], devMem[b][base]};
  endfunction

  task automatic doTxn(input int bank, input bit wr, input logic [7:0] addr,
                       input logic [31:0] wdata, input logic [3:0] be,
                       input logic [11:0] rdT, input logic [11:0] wrT,
                       input int waitHold, input bit scramble);
    logic [11:0] tm;
    logic [7:0]  base;
    int beats, laneBeats, enDly, ws, turn;
    int expLat, expStrobe, expSetup, expGap;
    int cycles, nStrobe, nSetup, nGap, badCs, overlap, holdCnt, holdBroke;
    bit holding, held;
    logic [1:0]  expCsN;
    logic [31:0] rdata;
    tm = wr ? wrT : rdT;
    base = {addr[7:2], 2'b00};
    beats = (bank == 0) ? 2 : 4;
    enDly = int'(tm[3:0]); ws = int'(tm[7:4]); turn = int'(tm[11:8]);
    laneBeats = 0;
    for (int k = 0; k < beats; k++) begin
      if (bank == 0) begin
        if (be[2*k +: 2] != 2'b00) laneBeats++;
      end else if (be[k]) laneBeats++;
    end
    if (!wr) laneBeats = beats;
    expStrobe = laneBeats * (1 + ws);
    expSetup  = beats * enDly + (beats - laneBeats) * (1 + ws);
    expGap    = (beats - 1) * turn;
    expLat    = beats * (enDly + 1 + ws) + (beats - 1) * turn + 1;
    expCsN    = (bank == 0) ? 2'b10 : 2'b01;
    cycles = 0; nStrobe = 0; nSetup = 0; nGap = 0; badCs = 0; overlap = 0;
    holdCnt = 0; holdBroke = 0; holding = 0; held = 0;

    cfgRdTiming[bank*12 +: 12] = rdT;
    cfgWrTiming[bank*12 +: 12] = wrT;
    reqValid = 1'b1; reqWrite = wr; reqBank = 1'(bank);
    reqAddr = {4'h0, addr}; reqWdata = wdata; reqByteEn = be;
    forever begin
      @(negedge clk);
      cycles++;
      if (reqReady) break;
      if (cycles > 4000) begin
        chk(1'b0, "R6", "ready timeout", cycles, expLat);
        break;
      end
      if (scramble && cycles == 3) begin
        reqWrite = ~wr; reqBank = ~reqBank; reqAddr = ~reqAddr;
        reqWdata = ~wdata; reqByteEn = ~be;
      end
      if (!memOeN && !memWeN) overlap++;
      if (!memOeN || !memWeN) nStrobe++;
      else if (memCsN != 2'b11) nSetup++;
      else nGap++;
      if (memCsN != 2'b11 && memCsN != expCsN) badCs++;
      if (holding) begin
        if (memOeN) holdBroke++;
        holdCnt++;
        if (holdCnt == waitHold) begin
          memWait = 1'b0;
          holding = 0;
        end
      end else if (waitHold > 0 && !held && !memOeN) begin
        memWait = 1'b1;
        holding = 1;
        held = 1;
      end
    end
    rdata = rspRdata;
    reqValid = 1'b0;

    if (waitHold == 0) begin
      chk(cycles == expLat, "R6", "latency", cycles, expLat);
      chk(nStrobe == expStrobe, "R4", "strobe cycles", nStrobe, expStrobe);
      chk(nSetup == expSetup, "R4", "setup cycles", nSetup, expSetup);
      chk(nGap == expGap, "R5", "turnaround cycles", nGap, expGap);
    end else begin
      chk(held && holdBroke == 0, "R8", "strobe released under wait", holdBroke, 0);
      chk(cycles > expLat, "R8", "wait stretches access", cycles, expLat + 1);
    end
    chk(badCs == 0, "R9", "wrong chip select", badCs, 0);
    chk(overlap == 0, "R10", "oe/we overlap", overlap, 0);
    if (wr) begin
      for (int k = 0; k < 4; k++)
        if (be[k]) refMem[bank][base + 8'(k)] = wdata[8*k +: 8];
      chk(devWord(bank, base) == refWord(bank, base), "R7",
          "memory after write", devWord(bank, base), refWord(bank, base));
    end else begin
      chk(rdata == refWord(bank, base), "R2", "read word", rdata, refWord(bank, base));
    end
    @(negedge clk);
    chk(!reqReady, "R11", "ready after valid dropped", reqReady, 0);
    repeat (turn + 2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog: actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int b = 0; b < NB; b++)
      for (int i = 0; i < 256; i++) refMem[b][i] = pat(b, i);

    // R1 reset state
    repeat (3) @(negedge clk);
    chk(memCsN == 2'b11, "R1", "cs in reset", memCsN, 2'b11);
    chk(memOeN && memWeN, "R1", "strobes in reset", {memOeN, memWeN}, 2'b11);
    chk(!reqReady && !memDataOe, "R1", "ready/oe in reset", {reqReady, memDataOe}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(memCsN == 2'b11 && memOeN && memWeN && !reqReady, "R1", "idle after reset",
        {memCsN, memOeN, memWeN, reqReady}, 5'b11110);

    // directed corners: R3 separate read/write sets at extremes
    doTxn(0, 0, 8'h13, 32'h0, 4'h0, 12'hFFF, 12'h000, 0, 0);
    doTxn(1, 1, 8'h42, 32'hA1B2C3D4, 4'b1010, 12'h000, 12'hFFF, 0, 0);
    doTxn(1, 0, 8'h40, 32'h0, 4'h0, 12'h121, 12'h000, 0, 0);
    // R7 empty lane set and partial halfword write
    doTxn(0, 1, 8'h20, 32'hDEADBEEF, 4'b0000, 12'h000, 12'h213, 0, 0);
    doTxn(0, 1, 8'h24, 32'h11223344, 4'b0110, 12'h000, 12'h101, 0, 0);
    doTxn(0, 0, 8'h24, 32'h0, 4'h0, 12'h000, 12'h000, 0, 0);
    // R8 wait stretch
    doTxn(0, 0, 8'h30, 32'h0, 4'h0, 12'h131, 12'h000, 8, 0);
    doTxn(1, 0, 8'h31, 32'h0, 4'h0, 12'h131, 12'h000, 6, 0);
    // R11 fields changed mid-transfer
    doTxn(1, 1, 8'h50, 32'h55667788, 4'b1111, 12'h222, 12'h112, 0, 1);
    doTxn(1, 0, 8'h50, 32'h0, 4'h0, 12'h000, 12'h000, 0, 1);

    // constrained random mix
    for (int n = 0; n < 80; n++) begin
      logic [11:0] rt, wt;
      rt = {4'($urandom % 4), 4'($urandom % 4), 4'($urandom % 4)};
      wt = {4'($urandom % 4), 4'($urandom % 4), 4'($urandom % 4)};
      doTxn(int'($urandom % 2), 1'($urandom), 8'($urandom), $urandom,
            4'($urandom), rt, wt, 0, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule